// File: doc/BRIEF.md
# Countdown-Triggered Fault Injection Controller

This block lets software plant artificial errors in a reliability error node at a chosen moment. Two 32-bit registers sit behind a small register port. One is a control word that holds a run enable, a restart choice and one enable per error class. The other holds a countdown value. Setting the run enable copies the countdown value into an internal counter, which then counts down by one each clock.

When the count expires, every error class whose enable is set becomes pending. There are four classes: corrected, deferred, recoverable/signaled and uncontainable. A pending class waits for the first cycle in which its eligible-operation strobe is high. In that cycle it drives a single-cycle inject pulse and then clears. With restart selected, the counter reloads from the countdown register on expiry and keeps going. Otherwise it stops.

Register select is one address bit: 0 is the control word and 1 is the countdown value. Read data is combinational from the address.

Top module: `fault_inject_ctrl`

## Requirements
- R1: After reset, both registers read 0x00000000 and `inject` is 0.
- R2: Control bits 31 (run enable), 30 (restart), 6, 5, 3 and 1 are writable and read back. Every other control bit reads 0 regardless of what is written.
- R3: The countdown register is a full 32-bit read/write register.
- R4: A control write with bit 31 set loads the countdown value N. With the strobes held high, the enabled classes inject in the cycle that begins N clock edges after the edge that accepted the write.
- R5: Class mapping for control bits and `op_elig`/`inject` bits:
  - control bit 6 selects corrected errors, index 0;
  - control bit 5 selects deferred errors, index 1;
  - control bit 3 selects recoverable/signaled errors, index 2;
  - control bit 1 selects uncontainable errors, index 3.
- R6: A pending class holds, with its output low, while its strobe is low. It pulses `inject` for exactly one cycle, combinationally, when the strobe is high, and then clears. `inject` is never high without its strobe.
- R7: With restart at 0, the counter stops after expiry and no further injection occurs. With restart at 1, it reloads and expires again every N cycles.
- R8: A write to the countdown register while counting does not change the current count. The new value takes effect at the next load or reload.
- R9: A control write with bit 31 clear halts counting and cancels all pending injections.
- R10: A countdown value of 0 expires on the load edge itself, so selected classes become pending at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control word, 1 selects countdown value |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| op_elig | input | 4 | Per-class eligible-operation strobes (index per R5) |
| inject | output | 4 | Per-class one-cycle inject pulses (index per R5) |

## Verification
The countdown is tried with values 0, 1 and several larger counts. Each is paired with single classes and with class mixes, which shows that the expiry delay tracks the loaded value and that each enable bit reaches its own output and no other. Directed patterns hold a strobe low past expiry and then release it, cancel with injections still pending, and run in restart mode. The restart run covers both an unchanged countdown register and one rewritten mid-count, which separates the current count from the reload value.

// File: rtl/fi_pkg.sv
package fi_pkg;
    localparam int REG_W   = 32;
    localparam int NUM_CLS = 4;
    localparam int RUN_BIT = 31;
    localparam int RST_BIT = 30;
    localparam int unsigned CLS_POS [NUM_CLS] = '{6, 5, 3, 1};

    typedef logic [NUM_CLS-1:0] cls_vec_t;

    typedef struct packed {
        logic     run;
        logic     restart;
        cls_vec_t cls;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[RUN_BIT] = 1'b1;
        m[RST_BIT] = 1'b1;
        for (int i = 0; i < NUM_CLS; i++) m[CLS_POS[i]] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] CTRL_MASK = ctrl_mask();

    function automatic ctrl_t decode(logic [REG_W-1:0] w);
        ctrl_t c;
        c.run     = w[RUN_BIT];
        c.restart = w[RST_BIT];
        for (int i = 0; i < NUM_CLS; i++) c.cls[i] = w[CLS_POS[i]];
        return c;
    endfunction
endpackage

// File: rtl/fi_regs.sv
module fi_regs
    import fi_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic         addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] cdn_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cdn_q  <= '0;
        end else if (wr) begin
            if (addr) cdn_q  <= wdata;
            else      ctrl_q <= wdata & CTRL_MASK;
        end
    end

    assign rdata = addr ? cdn_q : ctrl_q;
endmodule

// File: rtl/fi_countdown.sv
module fi_countdown #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         halt,
    input  logic         restart,
    input  logic [W-1:0] cdn,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic         running_q;
    logic         tick_end;

    assign tick_end = running_q && (cnt_q <= W'(1));
    assign expire   = load ? (cdn == '0) : (!halt && tick_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
        end else if (halt) begin
            running_q <= 1'b0;
        end else if (load) begin
            cnt_q     <= cdn;
            running_q <= (cdn != '0) || restart;
        end else if (tick_end) begin
            if (restart) begin
                cnt_q <= cdn;
            end else begin
                cnt_q     <= '0;
                running_q <= 1'b0;
            end
        end else if (running_q) begin
            cnt_q <= cnt_q - W'(1);
        end
    end
endmodule

// File: rtl/fi_arm.sv
module fi_arm #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         expire,
    input  logic [N-1:0] cls_en,
    input  logic         cancel,
    input  logic [N-1:0] strobe,
    output logic [N-1:0] inject
);
    for (genvar i = 0; i < N; i++) begin : g_cls
        logic pend_q;
        always_ff @(posedge clk) begin
            if (rst || cancel) pend_q <= 1'b0;
            else               pend_q <= (pend_q && !strobe[i]) || (expire && cls_en[i]);
        end
        assign inject[i] = pend_q && strobe[i];
    end
endmodule

// File: rtl/fault_inject_ctrl.sv
module fault_inject_ctrl
    import fi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NUM_CLS-1:0]   op_elig,
    output logic [NUM_CLS-1:0]   inject
);
    logic [REG_W-1:0] ctrl_q, cdn_q;
    ctrl_t            cur, wnew, eff;
    logic             ctrl_wr, load, halt, expire;

    fi_regs #(.W(REG_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .ctrl_q(ctrl_q), .cdn_q(cdn_q)
    );

    assign cur     = decode(ctrl_q);
    assign wnew    = decode(reg_wdata);
    assign ctrl_wr = reg_wr && !reg_addr;
    assign load    = ctrl_wr && wnew.run;
    assign halt    = ctrl_wr && !wnew.run;
    assign eff     = ctrl_wr ? wnew : cur;

    fi_countdown #(.W(REG_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .halt(halt),
        .restart(eff.restart), .cdn(cdn_q), .expire(expire)
    );

    fi_arm #(.N(NUM_CLS)) u_arm (
        .clk(clk), .rst(rst), .expire(expire), .cls_en(eff.cls),
        .cancel(halt), .strobe(op_elig), .inject(inject)
    );
endmodule

// File: rtl/fi_chk.sv
module fi_chk
    import fi_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic               reg_addr,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [REG_W-1:0]   reg_rdata,
    input logic [NUM_CLS-1:0] op_elig,
    input logic [NUM_CLS-1:0] inject
);
    p_resv_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !reg_addr |-> ((reg_rdata & ~CTRL_MASK) == '0));

    p_ctrl_back_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr) |=> (reg_addr || reg_wr || reg_rdata == ($past(reg_wdata) & CTRL_MASK)));

    p_cdn_back_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr) |=> (!reg_addr || reg_wr || reg_rdata == $past(reg_wdata)));

    p_strobe_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (inject & ~op_elig) == '0);

    p_cancel_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && !reg_wdata[RUN_BIT]) |=> (inject == '0));
endmodule

bind fault_inject_ctrl fi_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_elig(op_elig), .inject(inject)
);

// File: tb/tb_fault_inject_ctrl.sv
module tb_fault_inject_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic        reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [3:0]  op_elig;
    logic [3:0]  inject;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fault_inject_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_elig(op_elig), .inject(inject)
    );

    // {count[7:0], class mask[3:0]}
    localparam logic [11:0] VEC [7] = '{
        {8'd0, 4'b1111}, {8'd1, 4'b0001}, {8'd2, 4'b0010}, {8'd5, 4'b0100},
        {8'd7, 4'b1000}, {8'd3, 4'b1010}, {8'd4, 4'b0101}
    };

    // R5 mapping: class 0..3 -> control bits 6,5,3,1
    function automatic logic [31:0] cls_bits(logic [3:0] m);
        return {25'd0, m[0], m[1], 1'b0, m[2], 1'b0, m[3], 1'b0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        bad;
        int          hits;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0; op_elig = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        rd(1'b0, d); check("R1 ctrl", d, 32'h0);
        rd(1'b1, d); check("R1 cdn", d, 32'h0);
        check("R1 inject", {28'd0, inject}, 32'h0);

        wr(1'b1, 32'hA5A5_1234);
        rd(1'b1, d); check("R3 cdn readback", d, 32'hA5A5_1234);
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d); check("R2 ctrl mask", d, 32'hC000_006A);
        wr(1'b0, 32'h0);

        // R4 R5 R7 R10: table walk, strobes high, restart off
        op_elig = 4'hF;
        for (int v = 0; v < 7; v++) begin
            int n;
            logic [3:0] m;
            n = int'(VEC[v][11:4]);
            m = VEC[v][3:0];
            wr(1'b1, 32'(n));
            wr(1'b0, 32'h8000_0000 | cls_bits(m));
            bad = 1'b0;
            for (int k = 0; k <= n + 4; k++) begin
                if (k > 0) @(negedge clk);
                #1;
                if (inject !== ((k == n) ? m : 4'b0)) begin
                    bad = 1'b1;
                    $display("FAIL R4/R5/R7/R10 vec%0d k=%0d actual=%b expected=%b",
                             v, k, inject, (k == n) ? m : 4'b0);
                end
            end
            checks++;
            if (bad) errors++;
        end

        // R6: pending waits for strobe, then one pulse
        op_elig = 4'h0;
        wr(1'b1, 32'd2);
        wr(1'b0, 32'h8000_0000 | cls_bits(4'b0001));
        repeat (5) @(negedge clk);
        #1 check("R6 held while strobe low", {28'd0, inject}, 32'h0);
        op_elig = 4'b0001;
        #1 d = {28'd0, inject};
        @(negedge clk); #1;
        check("R6 single pulse", {d[3:0], inject}, {4'b0001, 4'b0000});
        op_elig = 4'h0;

        // R9: cancel pending
        wr(1'b1, 32'd2);
        wr(1'b0, 32'h8000_0000 | cls_bits(4'b1111));
        repeat (4) @(negedge clk);
        wr(1'b0, 32'h0);
        op_elig = 4'hF;
        bad = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            if (inject !== 4'b0) bad = 1'b1;
        end
        check("R9 cancel", {31'd0, bad}, 32'h0);

        // R7 restart: N=3 -> pulses at k=3,6,9,12
        wr(1'b1, 32'd3);
        wr(1'b0, 32'hC000_0000 | cls_bits(4'b0001));
        d = '0;
        for (int k = 0; k < 13; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            if (inject[0]) d[k] = 1'b1;
        end
        check("R7 restart period", d, 32'h0000_1248);
        wr(1'b0, 32'h0);

        // R8: rewrite countdown mid-run -> pulses at k=4,6,8
        op_elig = 4'b0010;
        wr(1'b1, 32'd4);
        wr(1'b0, 32'hC000_0000 | cls_bits(4'b0010));
        d = '0;
        hits = 0;
        for (int k = 0; k < 10; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            if (inject[1]) begin d[k] = 1'b1; hits++; end
            reg_wr = (k == 1); reg_addr = 1'b1; reg_wdata = 32'd2;
        end
        reg_wr = 1'b0;
        check("R8 deferred reload", d, 32'h0000_0150);
        wr(1'b0, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule